// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block guards a serial NOR flash array against writes and erases that land in a protected region. Software sets a four-bit block-protect value P and a top/bottom select through a single command register. The block turns them into a protected run of 64 KiB sectors. The run is anchored either at the highest sector or at sector 0. Its length is one sector shifted left by P−1, limited to the whole device. When P is zero, nothing is protected.

Write and erase requests come from the data path on a request port. Erase commands come from software through the command register. Each one is checked against the protected run. A legal operation is passed on one cycle later. An illegal one is dropped and sets a sticky interrupt flag. Software clears the flag by writing a 1 to its bit. The interrupt output is raised while any flag is set whose mask bit is also set. A chip-select register is held for the serial engine.

The device size comes from a fixed identification code: 2^(code−6) bytes. The address width, sector count and lock map are all derived from that code.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset, all of the following are zero: the status word, the interrupt flags, the interrupt mask, irq, fwd_valid, cmd_sector_go and cmd_bulk_go.
- R2: CSR word 0 (status) is read-only and reports BP[2:0] in bits 4:2, the top/bottom bit in bit 5 and BP[3] in bit 6. A command (word 2) with opcode 3 in bits 7:0 loads BP from bits 11:8 and top/bottom from bit 12. The new values are visible from the cycle after the write. A protect command with zero fields clears protection.
- R3: CSR word 1 returns the identification code ID_CODE (default 0x19). The device holds 2^(ID_CODE−6) bytes in 64 KiB sectors, which gives 8 sectors by default. The sector index of an address is its bits above bit 15.
- R4: With P = 0, no sector is locked. Otherwise the locked length is L = min(2^(P−1), sector count). With top/bottom = 0, sectors at or above count−L are locked. With top/bottom = 1, sectors below L are locked.
- R5: A request with req_valid=1 and req_erase=0 to an unlocked sector appears on fwd_valid one cycle later, with the same address and fwd_erase=0. To a locked sector it is dropped.
- R6: An erase request (req_erase=1) follows the same rule as R5 and is forwarded with fwd_erase=1. A sector erase command (opcode 2, sector index in bits 8 and up) gives a one-cycle cmd_sector_go with that index on the next cycle, unless the sector is locked.
- R7: A bulk erase command (opcode 1) gives a one-cycle cmd_bulk_go on the next cycle only when P = 0.
- R8: Any refused erase sets interrupt flag bit 0. A refused write sets bit 1. The flags are read at CSR word 3 and stay set until cleared.
- R9: Writing CSR word 3 clears each flag whose data bit is 1. A flag being set in the same cycle wins over the clear.
- R10: irq equals the OR of (flags AND mask). The mask is CSR word 4, bits 1:0, and can be read and written.
- R11: CSR word 5 holds CS_W read/write chip-select bits, which drive chip_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_sel | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 3 | CSR word index |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational from csr_addr |
| req_valid | input | 1 | Data-path request strobe |
| req_erase | input | 1 | 1 = erase, 0 = write |
| req_addr | input | ADDR_W (19) | Request byte address |
| fwd_valid | output | 1 | Accepted request strobe toward flash |
| fwd_erase | output | 1 | Kind of forwarded request |
| fwd_addr | output | ADDR_W (19) | Address of forwarded request |
| cmd_sector_go | output | 1 | Accepted sector erase command |
| cmd_sector_idx | output | SEC_W (3) | Sector index of that command |
| cmd_bulk_go | output | 1 | Accepted bulk erase command |
| chip_sel | output | CS_W (3) | Chip-select register value |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check the following on every cycle:
- a request to a locked sector is never forwarded;
- a bulk erase is never issued while P is non-zero;
- a protect command lands in the status field one cycle later;
- a set flag stays set unless a clear hits it, and a new event always sets its flag.

Some behaviour only the bench scenarios can show. The exact shape of the protected run is swept over all sixteen P values, both anchors and every sector, for writes, request erases and command erases. Its expected values are computed in the bench. The same holds for the set-over-clear priority, masking of the interrupt, the status bit layout and the reset values.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   typedef enum logic [2:0] {
      CSR_STATUS = 3'd0,
      CSR_ID     = 3'd1,
      CSR_CMD    = 3'd2,
      CSR_ISR    = 3'd3,
      CSR_IMR    = 3'd4,
      CSR_CSEL   = 3'd5
   } csr_word_e;

   localparam logic [7:0] OP_BULK = 8'd1;
   localparam logic [7:0] OP_SECT = 8'd2;
   localparam logic [7:0] OP_PROT = 8'd3;

   function automatic logic [31:0] status_word(input logic [3:0] bp, input logic tb);
      status_word = {25'd0, bp[3], tb, bp[2:0], 2'b00};
   endfunction
endpackage

// File: rtl/fpc_lockmap.sv
module fpc_lockmap #(
   parameter int SEC_W = 3,
   localparam int NSEC = 1 << SEC_W
) (
   input  logic [3:0]      bp,
   input  logic            tb,
   output logic [NSEC-1:0] lock_map
);
   logic [SEC_W:0] run_len;

   always_comb begin
      if (bp == 4'd0)
         run_len = '0;
      else if (32'(bp) - 32'd1 >= 32'(SEC_W))
         run_len = (SEC_W+1)'(NSEC);
      else
         run_len = (SEC_W+1)'(1) << (bp - 4'd1);
   end

   for (genvar g = 0; g < NSEC; g++) begin : g_sec
      if (g == 0) begin : g_first
         assign lock_map[g] = tb ? (run_len != '0) : (run_len == (SEC_W+1)'(NSEC));
      end else begin : g_rest
         assign lock_map[g] = tb ? (run_len > (SEC_W+1)'(g))
                                 : ((SEC_W+1)'(g) >= (SEC_W+1)'(NSEC) - run_len);
      end
   end
endmodule

// File: rtl/fpc_irq.sv
module fpc_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_erase,
   input  logic       set_write,
   input  logic       clr_we,
   input  logic [1:0] clr_bits,
   input  logic       mask_we,
   input  logic [1:0] mask_bits,
   output logic [1:0] flags,
   output logic [1:0] mask,
   output logic       irq
);
   logic [1:0] clr_eff;
   assign clr_eff = clr_we ? clr_bits : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= 2'b00;
         mask  <= 2'b00;
      end else begin
         flags <= (flags & ~clr_eff) | {set_write, set_erase};
         if (mask_we) mask <= mask_bits;
      end
   end

   assign irq = |(flags & mask);

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !clr_eff[0]) |=> flags[0]); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_write |=> flags[1]); // R9
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl #(
   parameter logic [7:0] ID_CODE  = 8'h19,
   parameter int         SEC_LOG2 = 16,
   parameter int         CS_W     = 3,
   localparam int ADDR_W = int'(ID_CODE) - 6,
   localparam int SEC_W  = ADDR_W - SEC_LOG2,
   localparam int NSEC   = 1 << SEC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_sel,
   input  logic              csr_we,
   input  logic [2:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              req_valid,
   input  logic              req_erase,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              fwd_valid,
   output logic              fwd_erase,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              cmd_sector_go,
   output logic [SEC_W-1:0]  cmd_sector_idx,
   output logic              cmd_bulk_go,
   output logic [CS_W-1:0]   chip_sel,
   output logic              irq
);
   import fpc_pkg::*;

   initial begin
      assert (SEC_W >= 1 && SEC_W <= 4) else $error("sector count out of range");
      assert (CS_W >= 1 && CS_W <= 32) else $error("chip select width out of range");
   end

   logic [3:0]      bp_q;
   logic            tb_q;
   logic [CS_W-1:0] cs_q;
   logic [NSEC-1:0] lock_map;
   logic [1:0]      flags, mask;

   logic wr_any, cmd_wr;
   logic [7:0] op;
   logic [SEC_W-1:0] req_sec, cmd_sec;
   logic req_lock, cmd_lock, bad_erase, bad_write;
   logic unused_wd;

   assign wr_any   = csr_sel && csr_we;
   assign cmd_wr   = wr_any && (csr_addr == CSR_CMD);
   assign op       = csr_wdata[7:0];
   assign req_sec  = req_addr[ADDR_W-1:SEC_LOG2];
   assign cmd_sec  = csr_wdata[8 +: SEC_W];
   assign req_lock = lock_map[req_sec];
   assign cmd_lock = lock_map[cmd_sec];
   assign unused_wd = ^csr_wdata;

   assign bad_write = req_valid && !req_erase && req_lock;
   assign bad_erase = (req_valid && req_erase && req_lock)
                    || (cmd_wr && op == OP_SECT && cmd_lock)
                    || (cmd_wr && op == OP_BULK && bp_q != 4'd0);

   fpc_lockmap #(.SEC_W(SEC_W)) u_map (
      .bp(bp_q), .tb(tb_q), .lock_map(lock_map));

   fpc_irq u_irq (
      .clk(clk), .rst_n(rst_n),
      .set_erase(bad_erase), .set_write(bad_write),
      .clr_we(wr_any && csr_addr == CSR_ISR), .clr_bits(csr_wdata[1:0]),
      .mask_we(wr_any && csr_addr == CSR_IMR), .mask_bits(csr_wdata[1:0]),
      .flags(flags), .mask(mask), .irq(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q           <= '0;
         tb_q           <= 1'b0;
         cs_q           <= '0;
         fwd_valid      <= 1'b0;
         fwd_erase      <= 1'b0;
         fwd_addr       <= '0;
         cmd_sector_go  <= 1'b0;
         cmd_sector_idx <= '0;
         cmd_bulk_go    <= 1'b0;
      end else begin
         if (cmd_wr && op == OP_PROT) begin
            bp_q <= csr_wdata[11:8];
            tb_q <= csr_wdata[12];
         end
         if (wr_any && csr_addr == CSR_CSEL) cs_q <= csr_wdata[CS_W-1:0];
         fwd_valid      <= req_valid && !req_lock;
         fwd_erase      <= req_erase;
         fwd_addr       <= req_addr;
         cmd_sector_go  <= cmd_wr && op == OP_SECT && !cmd_lock;
         cmd_sector_idx <= cmd_sec;
         cmd_bulk_go    <= cmd_wr && op == OP_BULK && bp_q == 4'd0;
      end
   end

   assign chip_sel = cs_q;

   always_comb begin
      case (csr_addr)
         CSR_STATUS: csr_rdata = status_word(bp_q, tb_q);
         CSR_ID:     csr_rdata = {24'd0, ID_CODE};
         CSR_ISR:    csr_rdata = {30'd0, flags};
         CSR_IMR:    csr_rdata = {30'd0, mask};
         CSR_CSEL:   csr_rdata = 32'(cs_q);
         default:    csr_rdata = 32'd0;
      endcase
   end

   AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lock) |=> !fwd_valid); // R5
   AST_BULK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && op == OP_BULK && bp_q != 4'd0) |=> !cmd_bulk_go); // R7
   AST_PROT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && op == OP_PROT) |=> (bp_q == $past(csr_wdata[11:8]) && tb_q == $past(csr_wdata[12]))); // R2
   AST_SECT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && op == OP_SECT && cmd_lock) |=> !cmd_sector_go); // R6
endmodule

// File: tb/flash_prot_ctrl_test.sv
module flash_prot_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csr_sel = 0, csr_we = 0;
   logic [2:0] csr_addr = 0;
   logic [31:0] csr_wdata = 0, csr_rdata;
   logic req_valid = 0, req_erase = 0;
   logic [18:0] req_addr = 0, fwd_addr;
   logic fwd_valid, fwd_erase, cmd_sector_go, cmd_bulk_go, irq;
   logic [2:0] cmd_sector_idx, chip_sel;

   int n_checks = 0, n_fail = 0;

   always #5 clk = ~clk;

   flash_prot_ctrl uut (
      .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .req_valid(req_valid), .req_erase(req_erase), .req_addr(req_addr),
      .fwd_valid(fwd_valid), .fwd_erase(fwd_erase), .fwd_addr(fwd_addr),
      .cmd_sector_go(cmd_sector_go), .cmd_sector_idx(cmd_sector_idx),
      .cmd_bulk_go(cmd_bulk_go), .chip_sel(chip_sel), .irq(irq));

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_sel = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_sel = 0; csr_we = 0; csr_wdata = 0;
   endtask

   task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
      csr_sel = 1; csr_we = 0; csr_addr = a;
      #1 d = csr_rdata;
      csr_sel = 0;
   endtask

   task automatic send_req(input logic er, input logic [18:0] ad);
      @(negedge clk);
      req_valid = 1; req_erase = er; req_addr = ad;
      @(negedge clk);
      req_valid = 0;
   endtask

   function automatic bit exp_lock(input int p, input int tb, input int s);
      int len;
      if (p == 0) return 0;
      len = (p - 1 >= 3) ? 8 : (1 << (p - 1));
      return tb ? (s < len) : (s >= 8 - len);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [18:0] ad;
      bit lk;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      csr_read(0, rd); check(rd == 0, "R1 status", rd, 0);
      csr_read(3, rd); check(rd == 0, "R1 flags", rd, 0);
      csr_read(4, rd); check(rd == 0, "R1 mask", rd, 0);
      check(!irq && !fwd_valid && !cmd_sector_go && !cmd_bulk_go, "R1 outputs",
            {irq, fwd_valid, cmd_sector_go, cmd_bulk_go}, 0);
      csr_read(1, rd); check(rd == 32'h19, "R3 id", rd, 32'h19);

      csr_write(5, 32'd5);
      csr_read(5, rd); check(rd == 5 && chip_sel == 3'd5, "R11 chip select", rd, 5);
      csr_write(4, 32'd3);
      csr_read(4, rd); check(rd == 3, "R10 mask readback", rd, 3);

      for (int p = 0; p < 16; p++) begin
         for (int tb = 0; tb < 2; tb++) begin
            logic [31:0] st;
            csr_write(2, (32'(tb) << 12) | (32'(p) << 8) | 32'd3);
            st = {25'd0, 1'(p >> 3), 1'(tb), 3'(p), 2'b00};
            csr_read(0, rd); check(rd == st, "R2 status layout", rd, st);
            for (int s = 0; s < 8; s++) begin
               lk = exp_lock(p, tb, s);
               ad = {3'(s), 16'h00a4 + 16'(s)};
               send_req(1'b0, ad);
               check(fwd_valid == !lk, "R4 R5 write forward", fwd_valid, !lk);
               if (!lk) check(fwd_addr == ad && !fwd_erase, "R5 write addr", fwd_addr, ad);
               csr_read(3, rd); check(rd == {30'd0, lk, 1'b0}, "R8 write flag", rd, {lk, 1'b0});
               check(irq == lk, "R10 irq", irq, lk);
               csr_write(3, 32'd3);
               csr_read(3, rd); check(rd == 0, "R9 clear", rd, 0);

               send_req(1'b1, ad);
               check(fwd_valid == !lk, "R6 erase request", fwd_valid, !lk);
               if (!lk) check(fwd_erase, "R6 erase kind", fwd_erase, 1);
               csr_read(3, rd); check(rd == {31'd0, lk}, "R8 erase flag", rd, lk);
               csr_write(3, 32'd3);

               csr_write(2, (32'(s) << 8) | 32'd2);
               check(cmd_sector_go == !lk, "R6 sector cmd", cmd_sector_go, !lk);
               if (!lk) check(cmd_sector_idx == 3'(s), "R6 sector idx", cmd_sector_idx, s);
               csr_read(3, rd); check(rd == {31'd0, lk}, "R8 cmd erase flag", rd, lk);
               csr_write(3, 32'd3);
            end
            csr_write(2, 32'd1);
            check(cmd_bulk_go == (p == 0), "R7 bulk", cmd_bulk_go, p == 0);
            csr_read(3, rd); check(rd[0] == (p != 0), "R7 bulk flag", rd, p != 0);
            csr_write(3, 32'd3);
         end
      end

      // protection still P=15, tb=1: every sector locked
      csr_write(4, 32'd0);
      send_req(1'b0, 19'h10000);
      check(!irq, "R10 masked irq", irq, 0);
      @(negedge clk);
      req_valid = 1; req_erase = 0; req_addr = 19'h20000;
      csr_sel = 1; csr_we = 1; csr_addr = 3; csr_wdata = 32'd2;
      @(negedge clk);
      req_valid = 0; csr_sel = 0; csr_we = 0; csr_wdata = 0;
      csr_read(3, rd); check(rd[1] == 1'b1, "R9 set over clear", rd, 2);
      csr_write(3, 32'd1);
      csr_read(3, rd); check(rd == 2, "R9 selective clear", rd, 2);

      csr_write(2, 32'd3);
      csr_read(0, rd); check(rd == 0, "R2 zero protect clears", rd, 0);
      send_req(1'b0, 19'h70000);
      check(fwd_valid, "R4 unlocked after clear", fwd_valid, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule